// File: doc/BRIEF.md
# Atomic Register-Memory Swap Sequencer

This block runs one swap instruction as a single memory transaction that cannot be split. It takes a 32-bit instruction word, a flag saying whether the instruction's condition passed, and two register values. One value is the address register and the other is the source register; the register file supplies both through a pair of read selects that the block drives from the instruction.

For a legal swap the block performs two memory beats while holding a bus lock and an interrupt-hold line. The first beat reads the word at the address, and the block keeps that word internally. The second beat writes the source register value to the same word-aligned address. In the cycle after the write is granted, the block writes the kept word back to the destination register.

Some instructions do not reach memory at all:
- an instruction whose condition failed,
- an instruction that does not encode a swap,
- an instruction that names the program counter (register 15) in any field,
- a misaligned access while the fault mode is selected.

Each of these retires with a status code and leaves memory and registers untouched. When fault mode is off, a misaligned address is allowed: memory is accessed at the aligned word and the loaded word is rotated.

Top module: `atomic_swap_unit`

## Requirements
- R1: An instruction is a swap only when bits 27..20 equal 8'b0001_0000 and bits 11..4 equal 8'b0000_1001; bits 31..28 are the condition field and are not decoded. Any other word whose condition passed retires with status ILLEGAL (2'd2), with no memory beat and no register write.
- R2: The address register index is bits 19..16, the destination index is bits 15..12 and the source index is bits 3..0. `rf_rsel_addr` and `rf_rsel_src` present the address and source indices of `req_instr` combinationally.
- R3: A legal aligned swap does three things in order. It issues a read beat. It then issues a write beat of the source value to the same aligned address. In the cycle after the write grant, it asserts `rf_we` for the destination with the read word, together with `done` and status OK (2'd0).
- R4: `mem_lock` and `irq_hold` are high in every cycle in which a read or write beat is requested, including stall cycles, and low in all other cycles.
- R5: When the destination and source indices are equal, memory receives the register's original value and the register receives the old memory word.
- R6: If any of the three register fields equals 15, the instruction retires with status ILLEGAL (2'd2), with no memory beat and no register write.
- R7: When `mmu_mode` is 0, a misaligned address is accessed at the address with its two low bits cleared. The loaded word is rotated right by 8 times the low two address bits before it is written back.
- R8: When `mmu_mode` is 1 and the low two address bits are nonzero, the instruction retires with status FAULT (2'd1), with no memory beat and no register write.
- R9: When `cond_pass` is 0 at acceptance, the instruction retires in the next cycle with status SKIP (2'd3) and no memory or register activity. This takes priority over R1, R6 and R8.
- R10: `done` is a one-cycle pulse, and it occurs exactly once for each accepted request.
- R11: `req_valid` is accepted only while the sequencer is idle. Requests presented while an instruction is in flight are ignored and produce no extra completion.
- R12: A beat whose grant is withheld keeps its request, write enable, address and write data steady until `mem_gnt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Instruction request |
| req_instr | input | 32 | Instruction word |
| cond_pass | input | 1 | Condition evaluated true |
| mmu_mode | input | 1 | 1: misaligned address faults, 0: loaded word rotates |
| rf_rsel_addr | output | 4 | Register-file read select for the address register |
| rf_rsel_src | output | 4 | Register-file read select for the source register |
| rf_rdata_addr | input | DATA_W | Address register value |
| rf_rdata_src | input | DATA_W | Source register value |
| rf_we | output | 1 | Destination write enable |
| rf_widx | output | 4 | Destination register index |
| rf_wdata | output | DATA_W | Destination write data |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_lock | output | 1 | Bus lock across both beats |
| mem_addr | output | ADDR_W | Word-aligned beat address |
| mem_wdata | output | DATA_W | Write beat data |
| mem_gnt | input | 1 | Beat accepted this cycle |
| mem_rdata | input | DATA_W | Read data, valid with the read grant |
| irq_hold | output | 1 | Interrupts held off |
| done | output | 1 | Completion pulse |
| status | output | 2 | 0 OK, 1 FAULT, 2 ILLEGAL, 3 SKIP |

## Verification
The sweep covers every combination of destination, address and source index, so all the aliasing cases and all placements of register 15 are hit. Offsets, fault mode and grant latency vary with the indices. A design that samples the source after write-back would store the new value when destination equals source. One that omitted any PC check would touch memory for an index of 15. A wrong rotation direction or a write to the unaligned address would corrupt the compared memory and register images. While each instruction is in flight, the bench keeps `req_valid` high with another legal swap; a sequencer that accepts it shows a second `done`. The bench also changes `mmu_mode` mid-flight, so a design that reads the mode late rotates wrongly.

// File: rtl/swap_pkg.sv
package swap_pkg;
   localparam int INSTR_W   = 32;
   localparam int REG_IDX_W = 4;
   localparam logic [REG_IDX_W-1:0] PC_IDX = 4'd15;
   localparam logic [7:0] OPC_HI = 8'b0001_0000;
   localparam logic [7:0] OPC_LO = 8'b0000_1001;

   typedef enum logic [1:0] {
      SW_OK      = 2'd0,
      SW_FAULT   = 2'd1,
      SW_ILLEGAL = 2'd2,
      SW_SKIP    = 2'd3
   } swap_status_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WRITE,
      ST_WBACK,
      ST_ABORT
   } swap_state_e;

   typedef struct packed {
      logic                 is_swap;
      logic                 names_pc;
      logic [REG_IDX_W-1:0] rn;
      logic [REG_IDX_W-1:0] rd;
      logic [REG_IDX_W-1:0] rm;
   } swap_fields_t;
endpackage

// File: rtl/swap_decode.sv
module swap_decode
   import swap_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output swap_fields_t       fields
);
   logic [3:0] unused_cond;
   assign unused_cond = instr[31:28];

   always_comb begin
      fields.rn       = instr[19:16];
      fields.rd       = instr[15:12];
      fields.rm       = instr[3:0];
      fields.is_swap  = (instr[27:20] == OPC_HI) && (instr[11:4] == OPC_LO);
      fields.names_pc = (instr[19:16] == PC_IDX) || (instr[15:12] == PC_IDX)
                        || (instr[3:0] == PC_IDX);
   end
endmodule

// File: rtl/swap_rotator.sv
module swap_rotator #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   localparam int LANES = DATA_W / LANE_W,
   localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [DATA_W-1:0] word_in,
   input  logic [SEL_W-1:0]  lane_sel,
   output logic [DATA_W-1:0] word_out
);
   logic [DATA_W-1:0] cand [LANES];

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      if (k == 0) begin : g_none
         assign cand[k] = word_in;
      end else begin : g_rot
         assign cand[k] = {word_in[k*LANE_W-1:0], word_in[DATA_W-1:k*LANE_W]};
      end
   end

   assign word_out = cand[lane_sel];
endmodule

// File: rtl/atomic_swap_unit.sv
module atomic_swap_unit
   import swap_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [31:0]       req_instr,
   input  logic              cond_pass,
   input  logic              mmu_mode,
   output logic [3:0]        rf_rsel_addr,
   output logic [3:0]        rf_rsel_src,
   input  logic [DATA_W-1:0] rf_rdata_addr,
   input  logic [DATA_W-1:0] rf_rdata_src,
   output logic              rf_we,
   output logic [3:0]        rf_widx,
   output logic [DATA_W-1:0] rf_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_lock,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_gnt,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              irq_hold,
   output logic              done,
   output logic [1:0]        status
);
   localparam int LANE_W = 8;
   localparam int LANES  = DATA_W / LANE_W;
   localparam int OFS_W  = (LANES > 1) ? $clog2(LANES) : 1;

   if (DATA_W % LANE_W != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of bytes");
   end
   if ((LANES & (LANES - 1)) != 0 || LANES < 2) begin : g_bad_lanes
      $error("DATA_W must hold a power-of-two byte count of at least two");
   end
   if (ADDR_W <= OFS_W || ADDR_W > DATA_W) begin : g_bad_addr
      $error("ADDR_W must exceed the offset width and fit in a register");
   end

   swap_fields_t  fld;
   swap_state_e   state_q;
   swap_status_e  status_q;
   logic [ADDR_W-1:0] addr_q;
   logic [OFS_W-1:0]  ofs_q;
   logic [DATA_W-1:0] src_q;
   logic [DATA_W-1:0] hold_q;
   logic [3:0]        dst_q;
   logic [DATA_W-1:0] rot_word;
   logic              misaligned;
   logic [ADDR_W-1:0] aligned_addr;

   swap_decode u_dec (
      .instr  (req_instr),
      .fields (fld)
   );

   swap_rotator #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_rot (
      .word_in  (mem_rdata),
      .lane_sel (ofs_q),
      .word_out (rot_word)
   );

   assign rf_rsel_addr = fld.rn;
   assign rf_rsel_src  = fld.rm;
   assign misaligned   = |rf_rdata_addr[OFS_W-1:0];
   assign aligned_addr = {rf_rdata_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         status_q <= SW_OK;
         addr_q   <= '0;
         ofs_q    <= '0;
         src_q    <= '0;
         hold_q   <= '0;
         dst_q    <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q <= aligned_addr;
                  ofs_q  <= mmu_mode ? '0 : rf_rdata_addr[OFS_W-1:0];
                  src_q  <= rf_rdata_src;
                  dst_q  <= fld.rd;
                  if (!cond_pass) begin
                     status_q <= SW_SKIP;
                     state_q  <= ST_ABORT;
                  end else if (!fld.is_swap || fld.names_pc) begin
                     status_q <= SW_ILLEGAL;
                     state_q  <= ST_ABORT;
                  end else if (mmu_mode && misaligned) begin
                     status_q <= SW_FAULT;
                     state_q  <= ST_ABORT;
                  end else begin
                     status_q <= SW_OK;
                     state_q  <= ST_READ;
                  end
               end
            end
            ST_READ: begin
               if (mem_gnt) begin
                  hold_q  <= rot_word;
                  state_q <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (mem_gnt) state_q <= ST_WBACK;
            end
            ST_WBACK: state_q <= ST_IDLE;
            ST_ABORT: state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
      mem_we    = (state_q == ST_WRITE);
      mem_lock  = mem_req;
      irq_hold  = mem_req;
      mem_addr  = addr_q;
      mem_wdata = src_q;
      rf_we     = (state_q == ST_WBACK);
      rf_widx   = dst_q;
      rf_wdata  = hold_q;
      done      = (state_q == ST_WBACK) || (state_q == ST_ABORT);
      status    = status_q;
   end
endmodule

// File: rtl/atomic_swap_unit_checker.sv
module atomic_swap_unit_checker #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_gnt,
   input logic              mem_lock,
   input logic              irq_hold,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [31:0]       mem_wdata,
   input logic              rf_we,
   input logic              done,
   input logic [1:0]        status
);
   assert_lock_on_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_lock && irq_hold));

   assert_lock_off_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req |-> (!mem_lock && !irq_hold));

   assert_aligned_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[OFS_W-1:0] == '0));

   assert_write_follows_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_gnt) |=> (mem_req && mem_we && $stable(mem_addr)));

   assert_wback_follows_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_gnt) |=> (rf_we && done && status == 2'd0));

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status != 2'd0) |-> (!rf_we && !mem_req));

   assert_stall_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                 && $stable(mem_wdata)));
endmodule

bind atomic_swap_unit atomic_swap_unit_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_gnt   (mem_gnt),
   .mem_lock  (mem_lock),
   .irq_hold  (irq_hold),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata[31:0]),
   .rf_we     (rf_we),
   .done      (done),
   .status    (status)
);

// File: tb/atomic_swap_unit_bench.sv
module atomic_swap_unit_bench;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n;
   logic        req_valid;
   logic [31:0] req_instr;
   logic        cond_pass, mmu_mode;
   logic [3:0]  rf_rsel_addr, rf_rsel_src, rf_widx;
   logic [31:0] rf_rdata_addr, rf_rdata_src, rf_wdata;
   logic        rf_we, mem_req, mem_we, mem_lock, mem_gnt, irq_hold, done;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [1:0]  status;

   logic [31:0] rf  [16];
   logic [31:0] mem [16];
   int lat = 0;
   int wait_cnt = 0;
   int n_rd = 0, n_wr = 0, n_done = 0, lock_bad = 0;
   logic [31:0] wr_addr = '0;
   int n_chk = 0, n_fail = 0;

   assign rf_rdata_addr = rf[rf_rsel_addr];
   assign rf_rdata_src  = rf[rf_rsel_src];
   assign mem_rdata     = mem[mem_addr[5:2]];
   assign mem_gnt       = mem_req && (wait_cnt >= lat);

   atomic_swap_unit u_atomic_swap_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_instr(req_instr),
      .cond_pass(cond_pass), .mmu_mode(mmu_mode),
      .rf_rsel_addr(rf_rsel_addr), .rf_rsel_src(rf_rsel_src),
      .rf_rdata_addr(rf_rdata_addr), .rf_rdata_src(rf_rdata_src),
      .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .irq_hold(irq_hold), .done(done), .status(status)
   );

   // Memory and register-file models; grant latency exercises R12 stalls.
   always @(posedge clk) begin
      if (mem_req && !mem_gnt) wait_cnt <= wait_cnt + 1;
      else wait_cnt <= 0;
      if (mem_req && mem_gnt) begin
         if (mem_we) begin
            mem[mem_addr[5:2]] <= mem_wdata;
            n_wr    <= n_wr + 1;
            wr_addr <= mem_addr;
         end else begin
            n_rd <= n_rd + 1;
         end
      end
      if (rf_we) rf[rf_widx] <= rf_wdata;
      if (done) n_done <= n_done + 1;
   end

   // R4: lock and interrupt hold track every requested beat.
   always @(negedge clk) begin
      if (rst_n && ((mem_lock !== mem_req) || (irq_hold !== mem_req)))
         lock_bad <= lock_bad + 1;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int rd, input int rn, input int rm);
      return {4'hE, 8'b0001_0000, 4'(rn), 4'(rd), 8'b0000_1001, 4'(rm)};
   endfunction

   task automatic run_one(input logic [31:0] instr, input int off, input bit mmu,
                          input bit cond, input int l);
      logic [31:0] exp_rf [16];
      logic [31:0] exp_mem [16];
      int rn, rd, rm, idx, b_rd, b_wr, b_done, b_lock, exp_rw, sh;
      logic [1:0] exp_st;
      logic [31:0] addr, old, rot;
      logic [63:0] dbl;
      bit swap_enc, seen;
      string tag;
      rn = int'(instr[19:16]); rd = int'(instr[15:12]); rm = int'(instr[3:0]);
      @(negedge clk);
      lat = l;
      for (int i = 0; i < 16; i++) begin
         rf[i]  = 32'hA500_0000 + 32'(i) * 32'h0001_0203;
         mem[i] = 32'h1122_3344 ^ (32'(i) * 32'h0101_0107);
      end
      idx = (rd * 3 + rm + rn) % 16;
      addr = 32'(idx * 4 + off);
      rf[rn] = addr;
      for (int i = 0; i < 16; i++) begin
         exp_rf[i] = rf[i]; exp_mem[i] = mem[i];
      end
      swap_enc = (instr[27:20] == 8'b0001_0000) && (instr[11:4] == 8'b0000_1001);
      if (!cond) begin exp_st = 2'd3; tag = "R9"; end
      else if (!swap_enc) begin exp_st = 2'd2; tag = "R1"; end
      else if (rn == 15 || rd == 15 || rm == 15) begin exp_st = 2'd2; tag = "R6"; end
      else if (mmu && off != 0) begin exp_st = 2'd1; tag = "R8"; end
      else begin exp_st = 2'd0; tag = (rd == rm) ? "R5" : ((off != 0) ? "R7" : "R3"); end
      exp_rw = (exp_st == 2'd0) ? 1 : 0;
      if (exp_st == 2'd0) begin
         old = mem[idx];
         sh  = mmu ? 0 : off;
         dbl = {old, old} >> (8 * sh);
         rot = dbl[31:0];
         exp_mem[idx] = rf[rm];
         exp_rf[rd]   = rot;
      end
      b_rd = n_rd; b_wr = n_wr; b_done = n_done; b_lock = lock_bad;
      req_valid = 1'b1; req_instr = instr; cond_pass = cond; mmu_mode = mmu;
      @(negedge clk);
      // R11: keep offering another legal swap while busy; mode flips too.
      req_instr = mk(1, 2, 3); cond_pass = 1'b1; mmu_mode = ~mmu;
      seen = 1'b0;
      for (int c = 0; c < 40; c++) begin
         if (done) begin seen = 1'b1; break; end
         @(negedge clk);
      end
      chk(seen, "R10", "done seen", 32'(seen), 32'd1);
      chk(status == exp_st, tag, "status", 32'(status), 32'(exp_st));
      req_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(n_done - b_done == 1, "R10/R11", "done count", 32'(n_done - b_done), 32'd1);
      chk(n_rd - b_rd == exp_rw, tag, "read beats", 32'(n_rd - b_rd), 32'(exp_rw));
      chk(n_wr - b_wr == exp_rw, tag, "write beats", 32'(n_wr - b_wr), 32'(exp_rw));
      if (exp_rw == 1)
         chk(wr_addr == {addr[31:2], 2'b00}, "R7", "write address", wr_addr,
             {addr[31:2], 2'b00});
      chk(lock_bad == b_lock, "R4", "lock tracks beats", 32'(lock_bad - b_lock), 32'd0);
      for (int i = 0; i < 16; i++) begin
         if (rf[i] !== exp_rf[i]) chk(1'b0, tag, $sformatf("rf[%0d]", i), rf[i], exp_rf[i]);
         if (mem[i] !== exp_mem[i]) chk(1'b0, tag, $sformatf("mem[%0d]", i), mem[i], exp_mem[i]);
      end
      n_chk++;
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_instr = '0; cond_pass = 1'b0; mmu_mode = 1'b0;
      for (int i = 0; i < 16; i++) begin rf[i] = '0; mem[i] = '0; end
      repeat (3) @(negedge clk);
      chk(!done && !mem_req && !rf_we && !mem_lock && !irq_hold, "R4", "reset quiet",
          {27'd0, done, mem_req, rf_we, mem_lock, irq_hold}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: read selects follow the instruction fields.
      req_instr = mk(7, 5, 9);
      #1;
      chk(rf_rsel_addr == 4'd5, "R2", "addr select", 32'(rf_rsel_addr), 32'd5);
      chk(rf_rsel_src == 4'd9, "R2", "src select", 32'(rf_rsel_src), 32'd9);
      // R1: broken encodings.
      run_one(mk(1, 2, 3) ^ 32'h0010_0000, 0, 1'b0, 1'b1, 0);
      run_one(mk(1, 2, 3) ^ 32'h0000_0040, 0, 1'b0, 1'b1, 1);
      run_one(mk(1, 2, 3) ^ 32'h0800_0000, 0, 1'b0, 1'b1, 0);
      // R9: failed condition, including a word that would otherwise be illegal.
      run_one(mk(4, 6, 8), 0, 1'b0, 1'b0, 0);
      run_one(mk(15, 6, 8), 1, 1'b1, 1'b0, 2);
      // Near-exhaustive sweep over all register triples (R3, R5, R6, R7, R8, R12).
      for (int rd = 0; rd < 16; rd++)
         for (int rn = 0; rn < 16; rn++)
            for (int rm = 0; rm < 16; rm++)
               run_one(mk(rd, rn, rm), (rd + rn + rm) % 4, 1'((rn ^ rm) & 1), 1'b1, rd % 3);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(4 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule